// File: doc/BRIEF.md
# Clock Domain Sleep and Wakeup Controller

This block runs the power-management state machine of one clock domain. Software picks the transition mode through a two-bit control field written over a simple write port. The block watches the enable and idle-status lines of the domain's modules, the standby flags of its masters, its optional clock enables and an external wakeup request. From these it decides whether the domain clock is running, being gated or asleep.

Only the software-sleep mode can put the domain to sleep. It does so once the full set of sleep conditions has held for two cycles in a row. The software-wakeup mode brings the domain back unconditionally, and while the parent power domain is off it also asks for that domain to be powered up. The no-sleep mode wakes the domain on any clock request, but only when the parent power domain is already on.

A small merge stage combines this domain's sleep flag with the flags of sibling clock domains. It signals when the shared power domain may move to its target state.

Top module: `clkdom_sleep_ctrl`

## Requirements
- R1: After a synchronous active-low reset the mode reads 2 (software wakeup), the state reads active (0), the clock is enabled and the error flag is clear.
- R2: A write of 0 (no-sleep), 1 (software sleep) or 2 (software wakeup) is visible on `mode_o` one cycle after the write strobe.
- R3: A write of 3 leaves the mode unchanged and sets `illegal_wr_err`, which stays set until reset.
- R4: In mode 1, the state goes from active to gating (1) after one cycle in which the sleep condition holds, and to asleep (2) after a second such cycle in a row. `clk_active` is low exactly while asleep.
- R5: In modes 0 and 2 an active domain never leaves the active state.
- R6: The sleep condition requires all of the following: no module enabled, every module idle status equal to 3, every optional clock off, every master standby bit at 1, and no wakeup request. A module whose idle status is 1 (transitioning) blocks sleep. When the condition fails while gating, the state returns to active.
- R7: In mode 2, `pd_wake_req` is high while `pd_on` is low. An asleep domain returns to active one cycle after it sees `pd_on` high, with no other event needed.
- R8: In mode 0, an asleep domain stays asleep while `pd_on` is low, even with a wakeup event, and `pd_wake_req` stays low. With `pd_on` high it wakes on an event: a module enabled, an optional clock on, a master out of standby, or a wakeup request.
- R9: `dom_state` uses the encoding 0 active, 1 gating, 2 asleep. `dom_asleep` is high exactly when the state is 2.
- R10: `pd_go_target` is high exactly when this domain is asleep and every bit of `sib_asleep` is 1.
- R11: In mode 1, an asleep domain wakes on a wakeup event when `pd_on` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Mode write strobe |
| ctl_wdata | input | 2 | Mode value to write |
| mod_en | input | N_MOD | Module enable (non-disabled mode) per module |
| mod_idlest | input | 2*N_MOD | Two-bit idle status per module, 3 = idle acknowledged |
| mst_stby | input | N_MST | Master standby flags, 1 = in standby |
| opt_clk_en | input | N_OPT | Optional clock enables |
| wkup_req | input | 1 | External wakeup request |
| pd_on | input | 1 | Parent power domain is powered |
| sib_asleep | input | N_SIB | Sleep flags of sibling clock domains |
| mode_o | output | 2 | Current transition mode |
| illegal_wr_err | output | 1 | Sticky flag for a write of value 3 |
| dom_state | output | 2 | Domain state: 0 active, 1 gating, 2 asleep |
| clk_active | output | 1 | Domain clock enable |
| dom_asleep | output | 1 | Domain is asleep |
| pd_wake_req | output | 1 | Request to power up the parent domain |
| pd_go_target | output | 1 | Power domain may enter its target state |

## Verification
A stuck or wrong state register shows up on `dom_state` and `clk_active` at the first sampling point after the edge where it went wrong. The reason is that both are read straight from the state register with no further pipeline. A wrong sleep-condition term shows up within two cycles as an early or missing step into gating or asleep. A corrupted mode register shows on `mode_o` and `pd_wake_req` in the very next cycle. The bench holds its own model of the mode, the run of qualifying cycles and the asleep flag, and compares every output after every clock.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;

  typedef enum logic [1:0] {
    MODE_NOSLEEP = 2'd0,
    MODE_SWSLEEP = 2'd1,
    MODE_SWWAKE  = 2'd2
  } ctl_mode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_GATING = 2'd1,
    ST_ASLEEP = 2'd2
  } dom_state_e;

  localparam logic [1:0] IDLE_ACKED   = 2'd3;
  localparam logic [1:0] MODE_ILLEGAL = 2'd3;

  // legal control values are 0..2
  function automatic logic mode_is_legal(input logic [1:0] v);
    return v != MODE_ILLEGAL;
  endfunction

endpackage

// File: rtl/clkdom_mode_reg.sv
module clkdom_mode_reg
  import clkdom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output ctl_mode_e  mode,
  output logic       err,
  output logic       bad_write
);

  logic good_write;

  assign bad_write  = wr && !mode_is_legal(wdata);
  assign good_write = wr &&  mode_is_legal(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_SWWAKE;
      err  <= 1'b0;
    end else begin
      if (good_write) mode <= ctl_mode_e'(wdata);
      if (bad_write)  err  <= 1'b1;
    end
  end

endmodule

// File: rtl/clkdom_idle_eval.sv
module clkdom_idle_eval
  import clkdom_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int N_MST = 2,
  parameter int N_OPT = 2
) (
  input  logic [N_MOD-1:0]   mod_en,
  input  logic [2*N_MOD-1:0] mod_idlest,
  input  logic [N_MST-1:0]   mst_stby,
  input  logic [N_OPT-1:0]   opt_clk_en,
  input  logic               wkup_req,
  output logic               sleep_ok,
  output logic               wake_evt
);

  logic [N_MOD-1:0] acked;

  for (genvar i = 0; i < N_MOD; i++) begin : g_ack
    assign acked[i] = (mod_idlest[2*i +: 2] == IDLE_ACKED);
  end

  logic modules_quiet, masters_quiet, clocks_quiet;

  assign modules_quiet = (mod_en == '0) && (&acked);
  assign masters_quiet = &mst_stby;
  assign clocks_quiet  = (opt_clk_en == '0);

  assign sleep_ok = modules_quiet && masters_quiet && clocks_quiet && !wkup_req;
  assign wake_evt = (|mod_en) || (|opt_clk_en) || !(&mst_stby) || wkup_req;

endmodule

// File: rtl/clkdom_state_fsm.sv
module clkdom_state_fsm
  import clkdom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_mode_e  mode,
  input  logic       sleep_ok,
  input  logic       wake_evt,
  input  logic       pd_on,
  output dom_state_e state
);

  function automatic dom_state_e next_of(input dom_state_e s, input ctl_mode_e m,
                                         input logic ok, input logic ev, input logic pwr);
    logic want_sleep;
    want_sleep = (m == MODE_SWSLEEP) && ok;
    case (s)
      ST_ACTIVE: return want_sleep ? ST_GATING : ST_ACTIVE;
      ST_GATING: return want_sleep ? ST_ASLEEP : ST_ACTIVE;
      ST_ASLEEP: return (pwr && ((m == MODE_SWWAKE) || ev)) ? ST_ACTIVE : ST_ASLEEP;
      default:   return ST_ACTIVE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_ACTIVE;
    else        state <= next_of(state, mode, sleep_ok, wake_evt, pd_on);
  end

endmodule

// File: rtl/pwrdom_merge.sv
module pwrdom_merge #(
  parameter int N_SIB = 2
) (
  input  logic             self_asleep,
  input  logic [N_SIB-1:0] sib_asleep,
  output logic             go_target
);

  assign go_target = self_asleep && (&sib_asleep);

endmodule

// File: rtl/clkdom_sleep_ctrl.sv
module clkdom_sleep_ctrl
  import clkdom_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int N_MST = 2,
  parameter int N_OPT = 2,
  parameter int N_SIB = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [1:0]         ctl_wdata,
  input  logic [N_MOD-1:0]   mod_en,
  input  logic [2*N_MOD-1:0] mod_idlest,
  input  logic [N_MST-1:0]   mst_stby,
  input  logic [N_OPT-1:0]   opt_clk_en,
  input  logic               wkup_req,
  input  logic               pd_on,
  input  logic [N_SIB-1:0]   sib_asleep,
  output logic [1:0]         mode_o,
  output logic               illegal_wr_err,
  output logic [1:0]         dom_state,
  output logic               clk_active,
  output logic               dom_asleep,
  output logic               pd_wake_req,
  output logic               pd_go_target
);

  ctl_mode_e  mode;
  dom_state_e state;
  logic       sleep_ok;
  logic       wake_evt;
  logic       bad_write;

  clkdom_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ctl_wr),
    .wdata     (ctl_wdata),
    .mode      (mode),
    .err       (illegal_wr_err),
    .bad_write (bad_write)
  );

  clkdom_idle_eval #(.N_MOD(N_MOD), .N_MST(N_MST), .N_OPT(N_OPT)) u_eval (
    .mod_en     (mod_en),
    .mod_idlest (mod_idlest),
    .mst_stby   (mst_stby),
    .opt_clk_en (opt_clk_en),
    .wkup_req   (wkup_req),
    .sleep_ok   (sleep_ok),
    .wake_evt   (wake_evt)
  );

  clkdom_state_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .sleep_ok (sleep_ok),
    .wake_evt (wake_evt),
    .pd_on    (pd_on),
    .state    (state)
  );

  pwrdom_merge #(.N_SIB(N_SIB)) u_merge (
    .self_asleep (dom_asleep),
    .sib_asleep  (sib_asleep),
    .go_target   (pd_go_target)
  );

  assign mode_o      = mode;
  assign dom_state   = state;
  assign dom_asleep  = (state == ST_ASLEEP);
  assign clk_active  = (state != ST_ASLEEP);
  assign pd_wake_req = (mode == MODE_SWWAKE) && !pd_on;

endmodule

// File: rtl/clkdom_sleep_ctrl_chk.sv
module clkdom_sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [1:0] ctl_wdata,
  input logic       pd_on,
  input logic [1:0] mode_o,
  input logic       illegal_wr_err,
  input logic [1:0] dom_state,
  input logic       clk_active,
  input logic       pd_go_target,
  input logic       sleep_ok,
  input logic       bad_write
);

  assert_illegal_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == 2'd3) |=> ($stable(mode_o) && illegal_wr_err));

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_wr_err && !bad_write) |=> illegal_wr_err);

  assert_stay_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd1 && dom_state == 2'd0) |=> dom_state == 2'd0);

  assert_gate_needs_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == 2'd1 && !sleep_ok) |=> dom_state == 2'd0);

  assert_clock_stops_after_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_active) |-> $past(dom_state) == 2'd1);

  assert_wake_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == 2'd2 && mode_o == 2'd2 && pd_on) |=> dom_state == 2'd0);

  assert_power_off_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_state == 2'd2 && !pd_on) |=> dom_state == 2'd2);

  assert_state_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dom_state != 2'd3);

  assert_target_only_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_go_target |-> !clk_active);

endmodule

bind clkdom_sleep_ctrl clkdom_sleep_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_wr         (ctl_wr),
  .ctl_wdata      (ctl_wdata),
  .pd_on          (pd_on),
  .mode_o         (mode_o),
  .illegal_wr_err (illegal_wr_err),
  .dom_state      (dom_state),
  .clk_active     (clk_active),
  .pd_go_target   (pd_go_target),
  .sleep_ok       (sleep_ok),
  .bad_write      (bad_write)
);

// File: tb/clkdom_sleep_ctrl_test.sv
module clkdom_sleep_ctrl_test;

  localparam int N_MOD = 4;
  localparam int N_MST = 2;
  localparam int N_OPT = 2;
  localparam int N_SIB = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               ctl_wr = 1'b0;
  logic [1:0]         ctl_wdata = '0;
  logic [N_MOD-1:0]   mod_en = '0;
  logic [2*N_MOD-1:0] mod_idlest = '1;
  logic [N_MST-1:0]   mst_stby = '1;
  logic [N_OPT-1:0]   opt_clk_en = '0;
  logic               wkup_req = 1'b0;
  logic               pd_on = 1'b1;
  logic [N_SIB-1:0]   sib_asleep = '0;
  logic [1:0]         mode_o;
  logic               illegal_wr_err;
  logic [1:0]         dom_state;
  logic               clk_active;
  logic               dom_asleep;
  logic               pd_wake_req;
  logic               pd_go_target;

  always #2 clk = ~clk;

  clkdom_sleep_ctrl #(.N_MOD(N_MOD), .N_MST(N_MST), .N_OPT(N_OPT), .N_SIB(N_SIB)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .mod_en(mod_en), .mod_idlest(mod_idlest), .mst_stby(mst_stby),
    .opt_clk_en(opt_clk_en), .wkup_req(wkup_req), .pd_on(pd_on),
    .sib_asleep(sib_asleep), .mode_o(mode_o), .illegal_wr_err(illegal_wr_err),
    .dom_state(dom_state), .clk_active(clk_active), .dom_asleep(dom_asleep),
    .pd_wake_req(pd_wake_req), .pd_go_target(pd_go_target)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  int m_mode = 2, m_err = 0, m_run = 0, m_asleep = 0;

  function automatic bit quiet_now();
    bit q = (mod_en == 0) && (opt_clk_en == 0) && !wkup_req;
    for (int i = 0; i < N_MOD; i++) if (mod_idlest[2*i +: 2] != 2'd3) q = 0;
    for (int i = 0; i < N_MST; i++) if (!mst_stby[i]) q = 0;
    return q;
  endfunction

  function automatic bit event_now();
    bit e = wkup_req;
    for (int i = 0; i < N_MOD; i++) if (mod_en[i]) e = 1;
    for (int i = 0; i < N_OPT; i++) if (opt_clk_en[i]) e = 1;
    for (int i = 0; i < N_MST; i++) if (!mst_stby[i]) e = 1;
    return e;
  endfunction

  function automatic int model_state();
    if (m_asleep != 0) return 2;
    return (m_run == 1) ? 1 : 0;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_mode = 2; m_err = 0; m_run = 0; m_asleep = 0;
      return;
    end
    if (m_asleep != 0) begin
      if (pd_on && (m_mode == 2 || event_now())) m_asleep = 0;
      m_run = 0;
    end else begin
      if (m_mode == 1 && quiet_now()) m_run++;
      else m_run = 0;
      if (m_run >= 2) begin m_asleep = 1; m_run = 0; end
    end
    if (ctl_wr) begin
      if (ctl_wdata == 2'd3) m_err = 1;
      else m_mode = ctl_wdata;
    end
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int st = model_state();
    chk(mode_o, m_mode, "R2 mode_o");
    chk(illegal_wr_err, m_err, "R3 illegal_wr_err");
    chk(dom_state, st, "R9 dom_state");
    chk(dom_asleep, st == 2, "R9 dom_asleep");
    chk(clk_active, st != 2, "R4 clk_active");
    chk(pd_wake_req, (m_mode == 2) && !pd_on, "R7 pd_wake_req");
    chk(pd_go_target, (st == 2) && (&sib_asleep), "R10 pd_go_target");
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic write_mode(input logic [1:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    tick();
    ctl_wr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) begin @(posedge clk); model_edge(); end
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(mode_o, 2, "R1 reset mode");
    chk(dom_state, 0, "R1 reset state");
    chk(clk_active, 1, "R1 reset clock");
    chk(illegal_wr_err, 0, "R1 reset err");

    // R5 mode 2 with quiet domain stays active
    repeat (4) tick();
    chk(dom_state, 0, "R5 wake mode stays active");
    write_mode(2'd0);
    repeat (4) tick();
    chk(dom_state, 0, "R5 nosleep mode stays active");

    // R3 illegal write
    write_mode(2'd3);
    chk(mode_o, 0, "R3 mode kept");
    chk(illegal_wr_err, 1, "R3 err set");

    // R4 two-cycle entry into sleep
    write_mode(2'd1);
    chk(dom_state, 0, "R4 active right after write");
    tick();
    chk(dom_state, 1, "R4 gating after one quiet cycle");
    chk(clk_active, 1, "R4 clock still on while gating");
    tick();
    chk(dom_state, 2, "R4 asleep after two quiet cycles");
    chk(clk_active, 0, "R4 clock off");

    // R10 merge with siblings
    sib_asleep = 2'b01; tick();
    chk(pd_go_target, 0, "R10 one sibling awake");
    sib_asleep = 2'b11; tick();
    chk(pd_go_target, 1, "R10 all asleep");
    chk(illegal_wr_err, 1, "R3 err still sticky");

    // R11 module enable wakes in sleep mode
    mod_en[2] = 1'b1; tick();
    chk(dom_state, 0, "R11 module enable wakes");
    mod_en[2] = 1'b0;

    // R6 transitioning idle status breaks gating
    tick();
    chk(dom_state, 1, "R6 gating again");
    mod_idlest[3:2] = 2'd1; tick();
    chk(dom_state, 0, "R6 transitioning module returns to active");
    repeat (3) tick();
    chk(dom_state, 0, "R6 transitioning module blocks sleep");
    mod_idlest[3:2] = 2'd3;
    mst_stby[1] = 1'b0; repeat (3) tick();
    chk(dom_state, 0, "R6 master out of standby blocks sleep");
    mst_stby[1] = 1'b1;
    opt_clk_en[0] = 1'b1; repeat (3) tick();
    chk(dom_state, 0, "R6 optional clock blocks sleep");
    opt_clk_en[0] = 1'b0;
    wkup_req = 1'b1; repeat (3) tick();
    chk(dom_state, 0, "R6 wakeup request blocks sleep");
    wkup_req = 1'b0;
    repeat (2) tick();
    chk(dom_state, 2, "R6 asleep once all quiet");

    // R8 nosleep mode with power off
    pd_on = 1'b0;
    write_mode(2'd0);
    wkup_req = 1'b1; repeat (3) tick();
    chk(dom_state, 2, "R8 stays asleep while power off");
    chk(pd_wake_req, 0, "R8 no power request");
    pd_on = 1'b1; tick();
    chk(dom_state, 0, "R8 wakes on event with power on");
    wkup_req = 1'b0; repeat (3) tick();
    chk(dom_state, 0, "R5 stays active after nosleep wake");

    // R7 software wakeup forces power
    write_mode(2'd1);
    repeat (2) tick();
    chk(dom_state, 2, "R4 asleep again");
    pd_on = 1'b0;
    write_mode(2'd2);
    chk(pd_wake_req, 1, "R7 power request raised");
    tick();
    chk(dom_state, 2, "R7 waits for power");
    pd_on = 1'b1; tick();
    chk(dom_state, 0, "R7 wakes without event");
    chk(pd_wake_req, 0, "R7 request drops with power on");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule